// File: doc/BRIEF.md
# DRAM Bank Timing Guard

This block sits between a memory controller's command scheduler and a four-bank double-data-rate graphics DRAM. Every cycle the scheduler offers one command: NOP, activate, read, write, precharge of one bank, or precharge of all banks. Each command carries a bank address. The guard keeps track of which banks hold an open row and when each timing window ends. In the same cycle it answers with exactly one of three results: grant, stall or error. One cycle later it passes each granted command on to the DRAM.

An early command is stalled but raises no error. The scheduler keeps presenting it until it is granted, and the guard sends NOP to the DRAM while the stall lasts. A command that can never be legal raises the error flag, and the scheduler is expected to drop it. Examples are a read to a closed bank, an activate to an open bank and an undefined command code.

Five cycle counts set the timing limits: activate-to-read, activate-to-write, activate-to-activate across banks, precharge-to-activate and same-bank activate-to-activate. Refresh, mode programming, data capture, burst spacing and row comparison are handled elsewhere.

Top module: `dram_bank_guard`

## Requirements
- R1: After reset all banks are closed, all timing windows have expired and `dram_cmd` is NOP (code 0). A NOP request (code 0) never raises `grant`, `stall` or `err`.
- R2: The command codes are NOP=0, ACT=1, READ=2, WRITE=3, PRE=4 and PRE-ALL=5. At most one of `grant`, `stall` and `err` is high in any cycle. Codes 6 and 7 raise `err` and are not forwarded.
- R3: A READ or WRITE to a closed bank raises `err`. It is never stalled and never granted.
- R4: Take an ACT granted in cycle t. A READ to that bank is granted no earlier than cycle t+`cfg_rcd_rd`, and a WRITE no earlier than cycle t+`cfg_rcd_wr`. A count of 0 or 1 allows the access in cycle t+1.
- R5: Two granted ACTs are at least `cfg_rrd` cycles apart, whatever their banks.
- R6: An ACT to an open bank raises `err`. Error takes precedence over any timing stall.
- R7: A PRE is always granted. If its bank is open, the PRE closes it, and the next ACT to that bank waits until `cfg_rp` cycles after the PRE. A PRE to a bank that is already closed changes no state.
- R8: A PRE-ALL is always granted. It closes every bank and restarts the precharge window of every bank, including banks that were already closed.
- R9: Two granted ACTs to the same bank are at least `cfg_rc` cycles apart.
- R10: A command granted in cycle t appears on `dram_cmd` and `dram_bank` in cycle t+1. In a cycle that follows a stall, an error or a NOP, `dram_cmd` is NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_cmd | input | 3 | Proposed command code |
| req_bank | input | BA_W | Bank addressed by the proposed command |
| cfg_rcd_rd | input | CNT_W | Minimum cycles from ACT to READ on a bank |
| cfg_rcd_wr | input | CNT_W | Minimum cycles from ACT to WRITE on a bank |
| cfg_rrd | input | CNT_W | Minimum cycles between any two ACTs |
| cfg_rp | input | CNT_W | Minimum cycles from precharge to ACT on a bank |
| cfg_rc | input | CNT_W | Minimum cycles between ACTs to one bank |
| grant | output | 1 | Proposed command accepted this cycle |
| stall | output | 1 | Proposed command is legal but early |
| err | output | 1 | Proposed command can never be legal in the current state |
| dram_cmd | output | 3 | Command sent to the DRAM, registered |
| dram_bank | output | BA_W | Bank sent to the DRAM, registered |

## Verification
The bench measures exact stall counts at each timing boundary. A counter that is off by one in either direction shows up as one stall too many or one too few.

It checks whether the same-bank cycle time or the precharge window governs a re-activation. Both are pending in that case, and a design that tested only one of them would grant too early.

It sends an ACT to an already closed bank just after a PRE-ALL. A design that restarted the precharge window only for open banks would grant that ACT at once.

It also sends a PRE to a closed bank and then an ACT to the same bank. A design that restarted the window on that PRE would stall the ACT.

Finally, it sends accesses to closed banks while other windows are running. A design that ranked stall above error would hold the scheduler where it should reject the command.

// File: rtl/dbg_pkg.sv
// Shared definitions for the DRAM bank timing guard.
// Assumes a 3-bit command field; codes 6 and 7 are undefined.
package dbg_pkg;

    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_PRE  = 3'd4,
        CMD_PREA = 3'd5,
        CMD_RSV6 = 3'd6,
        CMD_RSV7 = 3'd7
    } cmd_e;

endpackage

// File: rtl/dbg_downcnt.sv
// One timing window.
// A load with period P makes `expired` read 0 for the next P-1 cycles and 1
// from P cycles after the load onward. A period of 0 or 1 is therefore
// already expired in the cycle after the load.
// Assumes the load strobe lines up with the granted command.
module dbg_downcnt #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] period,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load the window on a strobe, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (period == '0) ? '0 : period - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The window is over once the count has reached zero.
    always_comb begin
        expired = (cnt == '0);
    end

endmodule

// File: rtl/dbg_bank.sv
// State of one DRAM bank: an open flag and four timing windows.
// act_go opens the bank and starts the read, write and cycle-time windows.
// pre_go closes the bank and starts its precharge window.
// Assumes act_go and pre_go are never both high.
module dbg_bank #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_go,
    input  logic             pre_go,
    input  logic [CNT_W-1:0] cfg_rcd_rd,
    input  logic [CNT_W-1:0] cfg_rcd_wr,
    input  logic [CNT_W-1:0] cfg_rp,
    input  logic [CNT_W-1:0] cfg_rc,
    output logic             is_open,
    output logic             rd_ok,
    output logic             wr_ok,
    output logic             act_ok
);

    logic rp_done;
    logic rc_done;

    // Track whether a row is open in this bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open <= 1'b0;
        end else if (act_go) begin
            is_open <= 1'b1;
        end else if (pre_go) begin
            is_open <= 1'b0;
        end
    end

    dbg_downcnt #(.W(CNT_W)) u_rcd_rd (
        .clk(clk), .rst_n(rst_n), .load(act_go), .period(cfg_rcd_rd), .expired(rd_ok)
    );

    dbg_downcnt #(.W(CNT_W)) u_rcd_wr (
        .clk(clk), .rst_n(rst_n), .load(act_go), .period(cfg_rcd_wr), .expired(wr_ok)
    );

    dbg_downcnt #(.W(CNT_W)) u_rc (
        .clk(clk), .rst_n(rst_n), .load(act_go), .period(cfg_rc), .expired(rc_done)
    );

    dbg_downcnt #(.W(CNT_W)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(pre_go), .period(cfg_rp), .expired(rp_done)
    );

    // An activate needs both the precharge window and the cycle-time window over.
    always_comb begin
        act_ok = rp_done && rc_done;
    end

endmodule

// File: rtl/dbg_decide.sv
// Combinational grant/stall/error decision for the command offered this cycle.
// An illegal command raises err even while a timing window is running.
// Assumes per-bank state is presented as flat vectors indexed by bank.
module dbg_decide #(
    parameter int BA_W  = 2,
    parameter int NBANK = 4
) (
    input  logic [dbg_pkg::CMD_W-1:0] req_cmd,
    input  logic [BA_W-1:0]           req_bank,
    input  logic [NBANK-1:0]          is_open,
    input  logic [NBANK-1:0]          rd_ok,
    input  logic [NBANK-1:0]          wr_ok,
    input  logic [NBANK-1:0]          act_ok,
    input  logic                      rrd_ok,
    output logic                      grant,
    output logic                      stall,
    output logic                      err
);
    import dbg_pkg::*;

    cmd_e cmd;
    logic sel_open;
    logic sel_rd;
    logic sel_wr;
    logic sel_act;

    // Pick out the addressed bank's state.
    always_comb begin
        cmd      = cmd_e'(req_cmd);
        sel_open = is_open[req_bank];
        sel_rd   = rd_ok[req_bank];
        sel_wr   = wr_ok[req_bank];
        sel_act  = act_ok[req_bank];
    end

    // Rank the outcome: error first, then timing, then grant.
    always_comb begin
        grant = 1'b0;
        stall = 1'b0;
        err   = 1'b0;
        case (cmd)
            CMD_NOP: ;
            CMD_ACT: begin
                if (sel_open)                err   = 1'b1;
                else if (sel_act && rrd_ok)  grant = 1'b1;
                else                         stall = 1'b1;
            end
            CMD_RD: begin
                if (!sel_open)   err   = 1'b1;
                else if (sel_rd) grant = 1'b1;
                else             stall = 1'b1;
            end
            CMD_WR: begin
                if (!sel_open)   err   = 1'b1;
                else if (sel_wr) grant = 1'b1;
                else             stall = 1'b1;
            end
            CMD_PRE:  grant = 1'b1;
            CMD_PREA: grant = 1'b1;
            default:  err   = 1'b1;
        endcase
    end

endmodule

// File: rtl/dram_bank_guard.sv
// DRAM bank timing guard (top).
// Checks each command the scheduler offers against the per-bank open state
// and timing windows, answers grant, stall or error in the same cycle, and
// passes a granted command on to the DRAM one cycle later.
// Assumes the scheduler holds a stalled command until it is granted.
module dram_bank_guard #(
    parameter int BA_W  = 2,
    parameter int CNT_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [dbg_pkg::CMD_W-1:0] req_cmd,
    input  logic [BA_W-1:0]           req_bank,
    input  logic [CNT_W-1:0]          cfg_rcd_rd,
    input  logic [CNT_W-1:0]          cfg_rcd_wr,
    input  logic [CNT_W-1:0]          cfg_rrd,
    input  logic [CNT_W-1:0]          cfg_rp,
    input  logic [CNT_W-1:0]          cfg_rc,
    output logic                      grant,
    output logic                      stall,
    output logic                      err,
    output logic [dbg_pkg::CMD_W-1:0] dram_cmd,
    output logic [BA_W-1:0]           dram_bank
);
    import dbg_pkg::*;

    localparam int NBANK = 1 << BA_W;

    logic [NBANK-1:0] act_go;
    logic [NBANK-1:0] pre_go;
    logic [NBANK-1:0] is_open;
    logic [NBANK-1:0] rd_ok;
    logic [NBANK-1:0] wr_ok;
    logic [NBANK-1:0] act_ok;
    logic             rrd_ok;
    logic             act_granted;
    logic             prea_granted;
    logic             pre_granted;

    // Decode which kind of command is being granted this cycle.
    always_comb begin
        act_granted  = grant && (req_cmd == CMD_ACT);
        pre_granted  = grant && (req_cmd == CMD_PRE);
        prea_granted = grant && (req_cmd == CMD_PREA);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Steer the activate and precharge strobes to this bank.
        always_comb begin
            act_go[b] = act_granted && (req_bank == BA_W'(b));
            pre_go[b] = prea_granted ||
                        (pre_granted && (req_bank == BA_W'(b)) && is_open[b]);
        end

        dbg_bank #(.CNT_W(CNT_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_go    (act_go[b]),
            .pre_go    (pre_go[b]),
            .cfg_rcd_rd(cfg_rcd_rd),
            .cfg_rcd_wr(cfg_rcd_wr),
            .cfg_rp    (cfg_rp),
            .cfg_rc    (cfg_rc),
            .is_open   (is_open[b]),
            .rd_ok     (rd_ok[b]),
            .wr_ok     (wr_ok[b]),
            .act_ok    (act_ok[b])
        );
    end

    dbg_downcnt #(.W(CNT_W)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(act_granted), .period(cfg_rrd), .expired(rrd_ok)
    );

    dbg_decide #(.BA_W(BA_W), .NBANK(NBANK)) u_decide (
        .req_cmd (req_cmd),
        .req_bank(req_bank),
        .is_open (is_open),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok),
        .act_ok  (act_ok),
        .rrd_ok  (rrd_ok),
        .grant   (grant),
        .stall   (stall),
        .err     (err)
    );

    // Forward a granted command to the DRAM, otherwise drive NOP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dram_cmd  <= CMD_NOP;
            dram_bank <= '0;
        end else if (grant) begin
            dram_cmd  <= req_cmd;
            dram_bank <= req_bank;
        end else begin
            dram_cmd  <= CMD_NOP;
            dram_bank <= '0;
        end
    end

endmodule

// File: rtl/dbg_guard_checker.sv
// Protocol checks on the guard's ports, attached to every instance by bind.
// Assumes cfg_rrd is stable across the cycle after an activate is granted.
module dbg_guard_checker #(
    parameter int BA_W  = 2,
    parameter int CNT_W = 6
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [dbg_pkg::CMD_W-1:0] req_cmd,
    input logic [BA_W-1:0]           req_bank,
    input logic [CNT_W-1:0]          cfg_rrd,
    input logic                      grant,
    input logic                      stall,
    input logic                      err,
    input logic [dbg_pkg::CMD_W-1:0] dram_cmd,
    input logic [BA_W-1:0]           dram_bank
);
    import dbg_pkg::*;

    assert_outcome_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant, stall, err}));

    assert_nop_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cmd == CMD_NOP) |-> (!grant && !stall && !err));

    assert_forward_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> (dram_cmd == $past(req_cmd)) && (dram_bank == $past(req_bank)));

    assert_hold_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !grant |=> (dram_cmd == CMD_NOP));

    assert_act_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && (req_cmd == CMD_ACT) && (cfg_rrd >= CNT_W'(2)))
        |=> !(grant && (req_cmd == CMD_ACT)));

    assert_pre_granted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_cmd == CMD_PRE) || (req_cmd == CMD_PREA)) |-> grant);

endmodule

bind dram_bank_guard dbg_guard_checker #(.BA_W(BA_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_cmd  (req_cmd),
    .req_bank (req_bank),
    .cfg_rrd  (cfg_rrd),
    .grant    (grant),
    .stall    (stall),
    .err      (err),
    .dram_cmd (dram_cmd),
    .dram_bank(dram_bank)
);

// File: tb/dram_bank_guard_tb.sv
`timescale 1ns/1ps
// Directed bench for the DRAM bank timing guard: one task per scenario.
module dram_bank_guard_tb;
    import dbg_pkg::*;

    localparam int BA_W  = 2;
    localparam int CNT_W = 6;
    localparam int T_RD  = 3;
    localparam int T_WR  = 2;
    localparam int T_RRD = 2;
    localparam int T_RP  = 3;
    localparam int T_RC  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       req_cmd = 3'd0;
    logic [BA_W-1:0]  req_bank = '0;
    logic [CNT_W-1:0] cfg_rcd_rd = CNT_W'(T_RD);
    logic [CNT_W-1:0] cfg_rcd_wr = CNT_W'(T_WR);
    logic [CNT_W-1:0] cfg_rrd = CNT_W'(T_RRD);
    logic [CNT_W-1:0] cfg_rp = CNT_W'(T_RP);
    logic [CNT_W-1:0] cfg_rc = CNT_W'(T_RC);
    logic             grant, stall, err;
    logic [2:0]       dram_cmd;
    logic [BA_W-1:0]  dram_bank;

    int checks = 0;
    int fails  = 0;
    logic [2:0]      exp_cmd  = 3'd0;
    logic [BA_W-1:0] exp_bank = '0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dram_bank_guard #(.BA_W(BA_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_cmd(req_cmd), .req_bank(req_bank),
        .cfg_rcd_rd(cfg_rcd_rd), .cfg_rcd_wr(cfg_rcd_wr), .cfg_rrd(cfg_rrd),
        .cfg_rp(cfg_rp), .cfg_rc(cfg_rc), .grant(grant), .stall(stall), .err(err),
        .dram_cmd(dram_cmd), .dram_bank(dram_bank)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // One cycle: present a command, check the previous cycle's forwarding, sample the answer.
    task automatic drive(input logic [2:0] c, input logic [BA_W-1:0] b,
                         output logic g, output logic s, output logic e);
        @(negedge clk);
        req_cmd  = c;
        req_bank = b;
        #1;
        check(dram_cmd == exp_cmd, "R10 forwarded command", dram_cmd, exp_cmd);
        if (exp_cmd != 3'd0)
            check(dram_bank == exp_bank, "R10 forwarded bank", dram_bank, exp_bank);
        g = grant; s = stall; e = err;
        exp_cmd  = g ? c : 3'd0;
        exp_bank = b;
    endtask

    task automatic idle(input int n);
        logic g, s, e;
        for (int i = 0; i < n; i++) drive(3'd0, '0, g, s, e);
    endtask

    // Offer a command until it is granted; count the stalls.
    task automatic hold(input logic [2:0] c, input logic [BA_W-1:0] b,
                        input int exp_stalls, input string req);
        logic g, s, e;
        int n = 0;
        for (int i = 0; i < 40; i++) begin
            drive(c, b, g, s, e);
            if (g) break;
            if (e || !s) begin
                check(0, {req, " unexpected error or no answer"}, e, 0);
                break;
            end
            n++;
        end
        check(n == exp_stalls, {req, " stall count"}, n, exp_stalls);
    endtask

    // Expect an error answer, with no grant and no stall.
    task automatic expect_err(input logic [2:0] c, input logic [BA_W-1:0] b, input string req);
        logic g, s, e;
        drive(c, b, g, s, e);
        check(e && !g && !s, req, {29'd0, g, s, e}, 1);
    endtask

    task automatic expect_grant(input logic [2:0] c, input logic [BA_W-1:0] b, input string req);
        logic g, s, e;
        drive(c, b, g, s, e);
        check(g && !s && !e, req, {29'd0, g, s, e}, 4);
    endtask

    task automatic test_reset();
        logic g, s, e;
        rst_n = 1'b0;
        idle(3);
        @(negedge clk);
        rst_n = 1'b1;
        exp_cmd = 3'd0;
        drive(3'd0, '0, g, s, e);
        check(!g && !s && !e, "R1 NOP quiet after reset", {29'd0, g, s, e}, 0);
        check(dram_cmd == 3'd0, "R1 dram idle after reset", dram_cmd, 0);
    endtask

    task automatic test_illegal();
        expect_err(CMD_RD, 2'd1, "R3 read to closed bank");
        expect_err(CMD_WR, 2'd2, "R3 write to closed bank");
        expect_err(3'd6, 2'd0, "R2 code 6 rejected");
        expect_err(3'd7, 2'd3, "R2 code 7 rejected");
    endtask

    task automatic test_rrd();
        hold(CMD_ACT, 2'd0, 0, "R1 first activate unhindered");
        hold(CMD_ACT, 2'd1, T_RRD - 1, "R5 activate spacing");
        idle(5);
    endtask

    task automatic test_rcd();
        hold(CMD_ACT, 2'd2, 0, "R4 activate bank 2");
        hold(CMD_RD, 2'd2, T_RD - 1, "R4 activate to read");
        idle(10);
        hold(CMD_ACT, 2'd3, 0, "R4 activate bank 3");
        hold(CMD_WR, 2'd3, T_WR - 1, "R4 activate to write");
        idle(10);
    endtask

    task automatic test_act_open();
        expect_err(CMD_ACT, 2'd1, "R6 activate to open bank");
    endtask

    task automatic test_trp();
        expect_grant(CMD_PRE, 2'd1, "R7 precharge open bank");
        expect_err(CMD_RD, 2'd1, "R7 bank closed by precharge");
        hold(CMD_ACT, 2'd1, T_RP - 2, "R7 precharge to activate");
        idle(10);
    endtask

    task automatic test_rcd_short();
        expect_grant(CMD_PRE, 2'd2, "R7 close bank 2");
        idle(10);
        cfg_rcd_rd = CNT_W'(1);
        hold(CMD_ACT, 2'd2, 0, "R4 activate with short read delay");
        hold(CMD_RD, 2'd2, 0, "R4 read delay of one");
        cfg_rcd_rd = CNT_W'(T_RD);
        idle(10);
    endtask

    task automatic test_pre_closed();
        expect_grant(CMD_PRE, 2'd2, "R7 close bank 2 again");
        idle(10);
        expect_grant(CMD_PRE, 2'd2, "R7 precharge of closed bank granted");
        hold(CMD_ACT, 2'd2, 0, "R7 precharge of closed bank leaves timers");
        expect_err(CMD_ACT, 2'd2, "R6 bank 2 open after activate");
        idle(10);
    endtask

    task automatic test_trc();
        expect_grant(CMD_PRE, 2'd3, "R9 close bank 3");
        idle(10);
        hold(CMD_ACT, 2'd3, 0, "R9 activate bank 3");
        expect_grant(CMD_PRE, 2'd3, "R9 early precharge");
        hold(CMD_ACT, 2'd3, T_RC - 2, "R9 same-bank activate cycle time");
        idle(10);
    endtask

    task automatic test_prea();
        expect_grant(CMD_PRE, 2'd2, "R8 close bank 2 before all-precharge");
        idle(10);
        expect_grant(CMD_PREA, 2'd0, "R8 precharge all");
        hold(CMD_ACT, 2'd2, T_RP - 1, "R8 closed bank window restarted");
        expect_err(CMD_RD, 2'd0, "R8 bank 0 closed");
        expect_err(CMD_WR, 2'd1, "R8 bank 1 closed");
        expect_err(CMD_RD, 2'd3, "R8 bank 3 closed");
        idle(2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        test_reset();
        test_illegal();
        test_rrd();
        test_rcd();
        test_act_open();
        test_trp();
        test_rcd_short();
        test_pre_closed();
        test_trc();
        test_prea();
        finish_run();
    end

    initial begin
        #(5.0 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule